// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM Generator

This block produces two independent pulse-width-modulated outputs. Each output alternates between a high phase and a low phase whose lengths are programmed directly as tick counts: a 16-bit high count and a 16-bit low count share one 32-bit count register per channel. There is no separate period register and no compare value. The period is simply the sum of the two counts. There is also no polarity control. An inverted waveform is obtained by swapping the two counts.

Each channel derives its ticks from one of four tick-source enable inputs. A 2-bit select chooses the input, a 7-bit divider thins the selected pulses, and a gate bit stops counting altogether. One shared control word holds, for both channels, the select, divider, gate and output-enable fields. Software reaches the three registers over a simple single-cycle write/read bus.

Each channel is built around a three-state sequencer with the states OFF, HIGH and LOW. The transitions are as follows:
- OFF->HIGH happens when the enable is seen set and the high count is nonzero.
- OFF->LOW happens when the enable is seen set and the high count is zero.
- HIGH->LOW happens when the high count has been used up.
- LOW->HIGH and LOW->LOW happen at the period boundary, where the new counts are latched. The sequencer goes to HIGH if the new high count is nonzero and stays in LOW if it is zero.
- Any state goes to OFF when the enable is clear.

Top module: `pwm_dual_hl`

## Requirements
- R1: After reset, all three registers read 0 and both outputs are low.
- R2: The count register of channel A is at offset 0x0, the count register of channel B is at offset 0x4 and the control register is at offset 0x8. Each register reads back the last value written. Control bits that hold no field read 0, so writing all ones reads back 0x00FFFFF3. Any other offset reads 0.
- R3: A count register holds the high count in bits 31:16 and the low count in bits 15:0. While the channel is enabled, its output is high for the high count of ticks, then low for the low count of ticks, and this repeats. Swapping the two counts inverts the duty.
- R4: The divider field is in control bits 14:8 for A and 22:16 for B. A value N gives one tick every N+1 pulses of the selected source.
- R5: The source select field is in control bits 5:4 for A and 7:6 for B. Its value picks which of the four tick-source inputs is counted.
- R6: The gate bit is control bit 15 for A and bit 23 for B. While it is clear, no ticks occur and an enabled output holds its level.
- R7: A high count of 0 keeps the output constantly low while the channel is enabled.
- R8: A low count of 0 with a nonzero high count still gives a low pulse one tick long in every period.
- R9: The enable bit is control bit 0 for A and bit 1 for B. Clearing it forces the output low in the first cycle after the write, without waiting for the period to end.
- R10: A count register written while the channel runs leaves the current period unchanged. The new counts take effect at the next period boundary.
- R11: Setting the enable bit starts the output at the beginning of a full high phase on the next clock, even if the channel was stopped part-way through a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one register per cycle |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_tick | input | 4 | Tick-source enable pulses, one per source |
| pwm_out | output | 2 | PWM outputs, bit 0 channel A, bit 1 channel B |

## Verification
Run lengths are measured at the outputs and compared with queued expectations for several count pairs:
- Asymmetric counts and their swap tell the high field apart from the low field.
- Equal single-tick counts expose off-by-one errors at each phase edge.
- A zero low count separates a minimum one-tick low from a missing one.

Further patterns cover the remaining fields:
- A divider of 2 and a half-rate source on select 3 tell a correct divider and mux from one that ignores the field or picks the wrong input.
- Frozen-level patterns separate a cleared gate and an idle source from a running one.
- Mid-period rewrites of the counts and of the enable tell boundary-timed updates and restarts apart from immediate or resumed ones.

// File: rtl/pwm_hl_pkg.sv
package pwm_hl_pkg;

    localparam int NCH        = 2;
    localparam int CNT_W      = 16;
    localparam int DIV_W      = 7;
    localparam int NSRC       = 4;
    localparam int SEL_W      = $clog2(NSRC);
    localparam int ADDR_W     = 4;

    // control word layout: per-channel fields repeat with a fixed stride
    localparam int EN_LSB     = 0;
    localparam int SEL_LSB    = 4;
    localparam int DIV_LSB    = 8;
    localparam int GATE_LSB   = 15;
    localparam int CH_STRIDE  = 8;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } chan_state_t;

    function automatic logic [63:0] ctrl_mask(input int nch, input int sel_w, input int div_w);
        logic [63:0] m;
        m = '0;
        for (int g = 0; g < nch; g++) begin
            m[EN_LSB + g] = 1'b1;
            for (int b = 0; b < sel_w; b++) m[SEL_LSB + sel_w * g + b] = 1'b1;
            for (int b = 0; b < div_w; b++) m[DIV_LSB + CH_STRIDE * g + b] = 1'b1;
            m[GATE_LSB + CH_STRIDE * g] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_hl_regs.sv
module pwm_hl_regs #(
    parameter int NCH    = 2,
    parameter int DW     = 32,
    parameter int AW     = 4,
    parameter logic [DW-1:0] CTRL_MASK = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic [NCH-1:0][DW-1:0] cnt_q,
    output logic [DW-1:0]         ctrl_q
);
    localparam logic [AW-1:0] CTRL_OFS = AW'(4 * NCH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else if (wr) begin
            for (int g = 0; g < NCH; g++) begin
                if (addr == AW'(4 * g)) cnt_q[g] <= wdata;
            end
            if (addr == CTRL_OFS) ctrl_q <= wdata & CTRL_MASK;
        end
    end

    always_comb begin
        rdata = '0;
        for (int g = 0; g < NCH; g++) begin
            if (addr == AW'(4 * g)) rdata = cnt_q[g];
        end
        if (addr == CTRL_OFS) rdata = ctrl_q;
    end

endmodule

// File: rtl/pwm_hl_tick.sv
module pwm_hl_tick #(
    parameter int NSRC  = 4,
    parameter int DIV_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          src,
    input  logic [$clog2(NSRC)-1:0]  sel,
    input  logic [DIV_W-1:0]         div,
    input  logic                     gate,
    output logic                     tick
);
    logic             pulse;
    logic [DIV_W-1:0] dcnt_q;

    assign pulse = src[sel];
    assign tick  = gate && pulse && (dcnt_q >= div);

    always_ff @(posedge clk) begin
        if (!rst_n || !gate) begin
            dcnt_q <= '0;
        end else if (pulse) begin
            dcnt_q <= (dcnt_q >= div) ? '0 : dcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_hl_chan.sv
module pwm_hl_chan
    import pwm_hl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] hi_in,
    input  logic [CNT_W-1:0] lo_in,
    output logic             pwm
);
    chan_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, hi_q, hi_d, lo_q, lo_d;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hi_d    = hi_q;
        lo_d    = lo_q;
        if (!en) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    hi_d    = hi_in;
                    lo_d    = lo_in;
                    cnt_d   = '0;
                    state_d = (hi_in == '0) ? ST_LOW : ST_HIGH;
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (cnt_inc >= {1'b0, hi_q}) begin
                            cnt_d   = '0;
                            state_d = ST_LOW;
                        end else begin
                            cnt_d = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                ST_LOW: begin
                    // a zero low count still ends after one tick
                    if (tick) begin
                        if (cnt_inc >= {1'b0, lo_q}) begin
                            hi_d    = hi_in;
                            lo_d    = lo_in;
                            cnt_d   = '0;
                            state_d = (hi_in == '0) ? ST_LOW : ST_HIGH;
                        end else begin
                            cnt_d = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
        end
    end

    always_comb begin
        pwm = en && (state_q == ST_HIGH);
    end

endmodule

// File: rtl/pwm_dual_hl.sv
module pwm_dual_hl
    import pwm_hl_pkg::*;
#(
    parameter int CH     = NCH,
    parameter int CW     = CNT_W,
    parameter int DVW    = DIV_W,
    parameter int NS     = NSRC,
    parameter int AW     = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [2*CW-1:0]   reg_wdata,
    output logic [2*CW-1:0]   reg_rdata,
    input  logic [NS-1:0]     src_tick,
    output logic [CH-1:0]     pwm_out
);
    localparam int DW  = 2 * CW;
    localparam int SW  = $clog2(NS);
    localparam logic [63:0] MASK64 = ctrl_mask(CH, SW, DVW);
    localparam logic [DW-1:0] CMASK = MASK64[DW-1:0];

    logic [CH-1:0][DW-1:0] cnt_w;
    logic [DW-1:0]         ctrl_w;

    pwm_hl_regs #(.NCH(CH), .DW(DW), .AW(AW), .CTRL_MASK(CMASK)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .cnt_q  (cnt_w),
        .ctrl_q (ctrl_w)
    );

    for (genvar g = 0; g < CH; g++) begin : g_ch
        localparam int SEL_P  = SEL_LSB + SW * g;
        localparam int DIV_P  = DIV_LSB + CH_STRIDE * g;
        localparam int GATE_P = GATE_LSB + CH_STRIDE * g;
        logic tick;

        pwm_hl_tick #(.NSRC(NS), .DIV_W(DVW)) u_tick (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (src_tick),
            .sel   (ctrl_w[SEL_P +: SW]),
            .div   (ctrl_w[DIV_P +: DVW]),
            .gate  (ctrl_w[GATE_P]),
            .tick  (tick)
        );

        pwm_hl_chan #(.CNT_W(CW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .en    (ctrl_w[EN_LSB + g]),
            .hi_in (cnt_w[g][DW-1:CW]),
            .lo_in (cnt_w[g][CW-1:0]),
            .pwm   (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_dual_hl_chk.sv
module pwm_dual_hl_chk #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] ctrl,
    input logic [1:0]    pwm_out
);
    localparam logic [DW-1:0] FIELD_BITS = DW'(32'h00FF_FFF3);

    // R9: a cleared enable leaves the output low
    a_r9_off_low_a: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |-> !pwm_out[0]);
    a_r9_off_low_b: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[1] |-> !pwm_out[1]);

    // R6: with the gate clear and the enable held, the level does not move
    a_r6_gate_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctrl[15]) && $past(ctrl[0], 2) && $past(ctrl[0]) && ctrl[0])
        |-> $stable(pwm_out[0]));
    a_r6_gate_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctrl[23]) && $past(ctrl[1], 2) && $past(ctrl[1]) && ctrl[1])
        |-> $stable(pwm_out[1]));

    // R2: a control write is held, with spare bits cleared
    a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(8)) |=> (ctrl == ($past(reg_wdata) & FIELD_BITS)));

endmodule

bind pwm_dual_hl pwm_dual_hl_chk #(.DW(32), .AW(4)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctrl      (ctrl_w),
    .pwm_out   (pwm_out)
);

// File: tb/pwm_dual_hl_test.sv
`timescale 1ns/1ps
module pwm_dual_hl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  src_tick = 4'b1001;
    logic [1:0]  pwm_out;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 0;
    int    q0[$];
    int    q1[$];
    bit    arm0 = 0, arm1 = 0;
    string sb_tag = "R3";

    pwm_dual_hl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_tick  (src_tick),
        .pwm_out   (pwm_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input int ch, input int sel, input int div, input bit gate);
        logic [31:0] c;
        c = '0;
        if (ch == 0) c = 32'h1 | (32'(sel) << 4) | (32'(div) << 8) | (32'(gate) << 15);
        else         c = 32'h2 | (32'(sel) << 6) | (32'(div) << 16) | (32'(gate) << 23);
        return c;
    endfunction

    // monitor: measures completed runs and pops the expected ones
    logic pl0 = 0, pl1 = 0;
    int   len0 = 0, len1 = 0;
    bit   act0 = 0, act1 = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!arm0) act0 = 0;
            if (pwm_out[0] !== pl0) begin
                if (act0 && q0.size() > 0) begin
                    int e;
                    e = q0.pop_front();
                    n_chk++;
                    if (e != int'(pl0) * 1000 + len0) begin
                        n_bad++;
                        $display("FAIL %s ch A run: actual lvl %0d len %0d expected lvl %0d len %0d",
                                 sb_tag, pl0, len0, e / 1000, e % 1000);
                    end
                end else if (arm0) act0 = 1;
                len0 = 1;
            end else len0++;
            pl0 = pwm_out[0];

            if (!arm1) act1 = 0;
            if (pwm_out[1] !== pl1) begin
                if (act1 && q1.size() > 0) begin
                    int e;
                    e = q1.pop_front();
                    n_chk++;
                    if (e != int'(pl1) * 1000 + len1) begin
                        n_bad++;
                        $display("FAIL %s ch B run: actual lvl %0d len %0d expected lvl %0d len %0d",
                                 sb_tag, pl1, len1, e / 1000, e % 1000);
                    end
                end else if (arm1) act1 = 1;
                len1 = 1;
            end else len1++;
            pl1 = pwm_out[1];
        end
    end

    task automatic push_exp(input int ch, input int lvl, input int len);
        if (ch == 0) q0.push_back(lvl * 1000 + len);
        else         q1.push_back(lvl * 1000 + len);
    endtask

    // driver: program, start, then queue the runs expected from the counts
    task automatic run_pattern(input string tag, input int ch, input int hi, input int lo,
                               input int div, input int sel, input int scale);
        int h, l;
        wr(4'h8, 32'h0);
        wr(4'(ch * 4), (32'(hi) << 16) | 32'(lo));
        wr(4'h8, ctrl_word(ch, sel, div, 1'b1));
        sb_tag = tag;
        do @(negedge clk); while (pwm_out[ch] !== 1'b1);
        #1;
        h = hi * scale;
        l = ((lo == 0) ? 1 : lo) * scale;
        for (int p = 0; p < 3; p++) begin
            push_exp(ch, 0, l);
            push_exp(ch, 1, h);
        end
        if (ch == 0) arm0 = 1; else arm1 = 1;
        repeat ((h + l) * 4 + 4) @(negedge clk);
        chk({tag, " all expected runs seen"}, (ch == 0) ? q0.size() : q1.size(), 0);
        #1;
        arm0 = 0; arm1 = 0;
        q0.delete(); q1.delete();
    endtask

    // source 3 pulses every other cycle
    initial begin
        forever begin
            @(negedge clk);
            src_tick[3] = ~src_tick[3];
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int h, cnt;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1
        rd(4'h0, d); chk("R1 count A after reset", d, 0);
        rd(4'h4, d); chk("R1 count B after reset", d, 0);
        rd(4'h8, d); chk("R1 control after reset", d, 0);
        chk("R1 outputs after reset", 32'(pwm_out), 0);

        // R2
        wr(4'h0, 32'hDEAD_BEEF); rd(4'h0, d); chk("R2 count A readback", d, 32'hDEAD_BEEF);
        wr(4'h4, 32'h1234_5678); rd(4'h4, d); chk("R2 count B readback", d, 32'h1234_5678);
        wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, d); chk("R2 control spare bits zero", d, 32'h00FF_FFF3);
        rd(4'hC, d); chk("R2 unmapped offset", d, 0);
        wr(4'h8, 32'h0);

        // R11: enable starts a full high phase on the next clock
        wr(4'h0, (32'd4 << 16) | 32'd4);
        wr(4'h8, ctrl_word(0, 0, 0, 1'b1));
        chk("R11 low in write cycle", 32'(pwm_out[0]), 0);
        h = 0;
        @(negedge clk);
        while (pwm_out[0] === 1'b1) begin h++; @(negedge clk); end
        chk("R11 first high length", h, 4);
        @(negedge clk);
        wr(4'h8, 32'h0);
        wr(4'h8, ctrl_word(0, 0, 0, 1'b1));
        h = 0;
        @(negedge clk);
        while (pwm_out[0] === 1'b1) begin h++; @(negedge clk); end
        chk("R11 restart from mid-low gives full high", h, 4);

        // R3 patterns, including the swap
        run_pattern("R3 hi3 lo5", 0, 3, 5, 0, 0, 1);
        run_pattern("R3 swapped hi5 lo3", 0, 5, 3, 0, 0, 1);
        run_pattern("R3 hi1 lo1", 0, 1, 1, 0, 0, 1);
        // R4 divider
        run_pattern("R4 div2", 0, 2, 3, 2, 0, 3);
        // R8 zero low count
        run_pattern("R8 lo0", 0, 4, 0, 0, 0, 1);
        // R5 channel B on half-rate source 3
        run_pattern("R5 B sel3", 1, 2, 2, 0, 3, 2);

        // R5: idle source 1 freezes channel A high
        wr(4'h8, 32'h0);
        wr(4'h0, (32'd2 << 16) | 32'd2);
        wr(4'h8, ctrl_word(0, 1, 0, 1'b1));
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out[0] !== 1'b1) cnt++; end
        chk("R5 idle source gives no ticks", cnt, 0);

        // R6: gate clear freezes channel A
        wr(4'h8, 32'h0);
        wr(4'h8, ctrl_word(0, 0, 0, 1'b0));
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out[0] !== 1'b1) cnt++; end
        chk("R6 gate clear holds level", cnt, 0);

        // R7: zero high count stays low
        wr(4'h8, 32'h0);
        wr(4'h0, (32'd0 << 16) | 32'd3);
        wr(4'h8, ctrl_word(0, 0, 0, 1'b1));
        cnt = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_out[0] !== 1'b0) cnt++; end
        chk("R7 high count zero stays low", cnt, 0);

        // R9: clearing enable mid-high forces low at once
        wr(4'h8, 32'h0);
        wr(4'h0, (32'd6 << 16) | 32'd4);
        wr(4'h8, ctrl_word(0, 0, 0, 1'b1));
        do @(negedge clk); while (pwm_out[0] !== 1'b1);
        wr(4'h8, 32'h0);
        chk("R9 low right after enable cleared", 32'(pwm_out[0]), 0);

        // R10: count write during high applies from the next period
        wr(4'h0, (32'd3 << 16) | 32'd3);
        wr(4'h8, ctrl_word(0, 0, 0, 1'b1));
        @(negedge clk);
        do @(negedge clk); while (!(pwm_out[0] === 1'b1 && pl0 === 1'b1 && len0 == 1));
        #1;
        sb_tag = "R10";
        push_exp(0, 0, 3); push_exp(0, 1, 6); push_exp(0, 0, 2); push_exp(0, 1, 6);
        arm0 = 1;
        wr(4'h0, (32'd6 << 16) | 32'd2);
        repeat (30) @(negedge clk);
        chk("R10 all expected runs seen", q0.size(), 0);
        arm0 = 0;
        q0.delete();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule